// File: doc/BRIEF.md
# SPI Register Bridge

This block lets an external SPI master (mode 0, 8-bit transfers) reach an internal 32-bit register bus. Every item the master sends is a 32-bit word carried as four bytes, least-significant byte first, with each byte sent most-significant bit first. The first word after chip select falls is a command. The command selects a burst write, a direct load of a control register, a read, or a status query. The words that follow are interpreted by that command.

The SPI pins are sampled by the system clock through a short synchroniser, so SCLK must be slow relative to `clk`: at least six `clk` cycles per SCLK half period. On the bus side, the bridge issues requests over a valid/ready channel. A request is held with stable fields until `req_ready` is seen high. The bridge never stalls the SPI side. A write data word that arrives while the previous request is still pending is dropped and flagged. Read responses come back on `rsp_valid`/`rsp_rdata` with no back-pressure, at least one cycle after the read request was accepted. Reads prefetch one word ahead into a single buffer.

Errors are collected in sticky flags. A query returns them in its next word, under the fixed identity 0x1608, and clears them as they are returned.

Top module: `spi_reg_bridge`

## Requirements
- R1: A 32-bit word is assembled from four consecutive SPI bytes, least-significant byte first. Within each byte the most-significant bit comes first. MOSI is sampled on rising SCLK while chip select is low. MISO carries outgoing words in the same order.
- R2: Command 0x00000011 is followed by an address word and then data words. Each data word produces one write request. The first goes to that address and each later one goes 4 higher.
- R3: Once `req_valid` is high, it stays high until `req_ready` is seen. Until then `req_addr`, `req_wdata` and `req_write` do not change.
- R4: A write data word that completes while a request is still pending is dropped and sets status bit 0 (write error).
- R5: An operation moves at most MAX_OP_BYTES/4 words. Write data words beyond that limit issue no request and set status bit 1 (write overflow).
- R6: Command 0x00030011 loads the next word into `ctrl0` and issues no bus request. Later words in the same frame are ignored.
- R7: A read command has 0x0077 in bits 15:0 and a word count N in bits 31:16. It is followed by an address word, one dummy word and the read-begin word 0x000000AA. The next N words on MISO are the register values at the address, address+4 and so on. Any further words read as zero.
- R8: A read count above the limit of R5 is clamped to the limit and sets status bit 9 (read underflow).
- R9: A read-begin word other than 0x000000AA sets status bit 10 (pre-read error). The rest of that frame returns zeros.
- R10: A read data word whose value has not arrived from the bus by the time it must be shifted out is sent as zero and sets status bit 8 (read error).
- R11: Command 0x000000FF makes the next MISO word equal {16'h1608, flags}. Flags are sticky until returned this way, and are cleared when returned.
- R12: Raising chip select in the middle of a word discards the partial word. If the frame was a burst write or a control load, this sets status bit 2 (write unfinished).
- R13: Any other command word is ignored for the rest of the frame: no request, no change to `ctrl0`, no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock from master (idle low) |
| spi_cs_n | input | 1 | SPI chip select, active low; frames an operation |
| spi_mosi | input | 1 | Serial data from master |
| spi_miso | output | 1 | Serial data to master |
| req_valid | output | 1 | Bus request valid |
| req_ready | input | 1 | Bus accepts the request this cycle |
| req_write | output | 1 | 1 = write request, 0 = read request |
| req_addr | output | 32 | Request byte address |
| req_wdata | output | 32 | Write data |
| rsp_valid | input | 1 | Read data valid, one cycle per accepted read |
| rsp_rdata | input | 32 | Read data |
| ctrl0 | output | 32 | Control register loaded by command 0x00030011 |

## Verification
Bursts of distinct multi-byte values are written and then read back over SPI. This separates a wrong byte or bit order from a wrong address stride. Bursts longer than a reduced operation limit, and reads with a count above it, show whether extra words are cut off, whether the read tail reads as zero, and which flag records each case. A stalled bus is used twice. During a write it shows a held request and a dropped second word. During a read it shows the zero word sent in place of late data. A wrong read-begin token, a frame cut off mid-word, and an unknown command show that each error lands in its own status bit. Repeated queries show that the flags are sticky and are cleared once reported.

// File: rtl/spi_bridge_pkg.sv
`timescale 1ns/1ps
package spi_bridge_pkg;
  localparam int WORD_W = 32;
  localparam int CNT_W  = $clog2(WORD_W);
  localparam int FLAG_W = 16;

  localparam logic [31:0] CMD_BURST_WR = 32'h0000_0011;
  localparam logic [31:0] CMD_CTRL_WR  = 32'h0003_0011;
  localparam logic [31:0] CMD_STATUS   = 32'h0000_00FF;
  localparam logic [15:0] RD_OPCODE    = 16'h0077;
  localparam logic [31:0] RD_GO_TOKEN  = 32'h0000_00AA;
  localparam logic [15:0] STATUS_ID    = 16'h1608;

  localparam int FL_WERR  = 0;
  localparam int FL_WOVF  = 1;
  localparam int FL_WUNF  = 2;
  localparam int FL_RERR  = 8;
  localparam int FL_RUND  = 9;
  localparam int FL_PRERR = 10;

  typedef enum logic [3:0] {
    S_CMD, S_WADDR, S_WDATA, S_CDATA, S_RADDR,
    S_RDUMMY, S_RBEGIN, S_RDATA, S_QDATA, S_SKIP
  } op_state_e;

  // bit position inside the word for the n-th bit on the wire
  function automatic logic [CNT_W-1:0] wire_bit(input logic [CNT_W-1:0] n);
    return {n[CNT_W-1:3], ~n[2:0]};
  endfunction
endpackage

// File: rtl/sb_spi_front.sv
`timescale 1ns/1ps
module sb_spi_front
  import spi_bridge_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic              tx_load,
  input  logic [WORD_W-1:0] tx_word,
  output logic              word_done,
  output logic [WORD_W-1:0] rx_word,
  output logic              frame_end,
  output logic              frame_mid
);
  logic [SYNC_STAGES-1:0] sclk_sr, cs_sr, mosi_sr;
  logic                   sclk_prev, cs_prev;
  logic [CNT_W-1:0]       bit_cnt;
  logic [WORD_W-1:0]      rx_q, tx_q;
  logic                   sclk_s, cs_s, mosi_s, sclk_rise;

  assign sclk_s    = sclk_sr[SYNC_STAGES-1];
  assign cs_s      = cs_sr[SYNC_STAGES-1];
  assign mosi_s    = mosi_sr[SYNC_STAGES-1];
  assign sclk_rise = sclk_s & ~sclk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sr <= '0;
      cs_sr   <= '1;
      mosi_sr <= '0;
    end else begin
      sclk_sr <= {sclk_sr[SYNC_STAGES-2:0], spi_sclk};
      cs_sr   <= {cs_sr[SYNC_STAGES-2:0], spi_cs_n};
      mosi_sr <= {mosi_sr[SYNC_STAGES-2:0], spi_mosi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev <= 1'b0;
      cs_prev   <= 1'b1;
      bit_cnt   <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      word_done <= 1'b0;
      frame_end <= 1'b0;
      frame_mid <= 1'b0;
    end else begin
      sclk_prev <= sclk_s;
      cs_prev   <= cs_s;
      word_done <= 1'b0;
      frame_end <= 1'b0;
      if (cs_s) begin
        bit_cnt <= '0;
        if (!cs_prev) begin
          frame_end <= 1'b1;
          frame_mid <= (bit_cnt != '0);
        end
      end else if (sclk_rise) begin
        rx_q[wire_bit(bit_cnt)] <= mosi_s;
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == CNT_W'(WORD_W - 1)) word_done <= 1'b1;
      end
      if (tx_load) tx_q <= tx_word;
    end
  end

  assign rx_word  = rx_q;
  assign spi_miso = tx_q[wire_bit(bit_cnt)];
endmodule

// File: rtl/sb_flags.sv
`timescale 1ns/1ps
module sb_flags
  import spi_bridge_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_W-1:0] set_i,
  input  logic              take_i,
  output logic [FLAG_W-1:0] flags_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_o <= '0;
    else        flags_o <= (take_i ? '0 : flags_o) | set_i;
  end
endmodule

// File: rtl/sb_req_port.sv
`timescale 1ns/1ps
module sb_req_port
  import spi_bridge_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_i,
  input  logic              issue_write_i,
  input  logic [WORD_W-1:0] issue_addr_i,
  input  logic [WORD_W-1:0] issue_data_i,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [WORD_W-1:0] req_addr,
  output logic [WORD_W-1:0] req_wdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_write <= 1'b0;
      req_addr  <= '0;
      req_wdata <= '0;
    end else if (req_valid) begin
      if (req_ready) req_valid <= 1'b0;
    end else if (issue_i) begin
      req_valid <= 1'b1;
      req_write <= issue_write_i;
      req_addr  <= issue_addr_i;
      req_wdata <= issue_data_i;
    end
  end
endmodule

// File: rtl/spi_reg_bridge.sv
`timescale 1ns/1ps
module spi_reg_bridge
  import spi_bridge_pkg::*;
#(
  parameter int MAX_OP_BYTES = 60000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        spi_sclk,
  input  logic        spi_cs_n,
  input  logic        spi_mosi,
  output logic        spi_miso,
  output logic        req_valid,
  input  logic        req_ready,
  output logic        req_write,
  output logic [31:0] req_addr,
  output logic [31:0] req_wdata,
  input  logic        rsp_valid,
  input  logic [31:0] rsp_rdata,
  output logic [31:0] ctrl0
);
  localparam logic [15:0] MAX_WORDS = 16'(MAX_OP_BYTES / 4);

  op_state_e         state;
  logic              word_done, frame_end, frame_mid;
  logic [WORD_W-1:0] rx_word, tx_word;
  logic              tx_load;
  logic [FLAG_W-1:0] flag_set, flags_q;
  logic              flag_take;
  logic              iss, iss_w;
  logic [WORD_W-1:0] iss_a, iss_d;
  logic [WORD_W-1:0] addr_q, fetch_addr, rbuf, ctrl0_q;
  logic [15:0]       left_q, fetch_left, rd_count;
  logic              rbuf_v, rd_out, drop_q;
  logic              is_read_cmd, consume, fetch_ok;

  sb_spi_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk, .rst_n, .spi_sclk, .spi_cs_n, .spi_mosi, .spi_miso,
    .tx_load, .tx_word, .word_done, .rx_word, .frame_end, .frame_mid
  );

  sb_flags u_flags (
    .clk, .rst_n, .set_i(flag_set), .take_i(flag_take), .flags_o(flags_q)
  );

  sb_req_port u_req (
    .clk, .rst_n, .issue_i(iss), .issue_write_i(iss_w), .issue_addr_i(iss_a),
    .issue_data_i(iss_d), .req_valid, .req_ready, .req_write, .req_addr, .req_wdata
  );

  assign is_read_cmd = (rx_word[15:0] == RD_OPCODE);
  assign rd_count    = (rx_word[31:16] > MAX_WORDS) ? MAX_WORDS : rx_word[31:16];
  assign consume     = word_done && left_q != '0 &&
                       ((state == S_RBEGIN && rx_word == RD_GO_TOKEN) || state == S_RDATA);
  assign fetch_ok    = !word_done && !frame_end && fetch_left != '0 && !rbuf_v &&
                       !rd_out && !req_valid && !drop_q &&
                       (state == S_RDUMMY || state == S_RBEGIN || state == S_RDATA);

  always_comb begin
    flag_set  = '0;
    flag_take = 1'b0;
    tx_load   = 1'b0;
    tx_word   = '0;
    iss       = 1'b0;
    iss_w     = 1'b0;
    iss_a     = fetch_addr;
    iss_d     = rx_word;
    if (frame_end) begin
      tx_load = 1'b1;
      if (frame_mid && (state == S_WADDR || state == S_WDATA || state == S_CDATA))
        flag_set[FL_WUNF] = 1'b1;
    end else if (word_done) begin
      tx_load = 1'b1;
      case (state)
        S_CMD: begin
          if (rx_word == CMD_STATUS) begin
            tx_word   = {STATUS_ID, flags_q};
            flag_take = 1'b1;
          end else if (is_read_cmd && rx_word[31:16] > MAX_WORDS) begin
            flag_set[FL_RUND] = 1'b1;
          end
        end
        S_WDATA: begin
          if (left_q == '0) flag_set[FL_WOVF] = 1'b1;
          else if (req_valid) flag_set[FL_WERR] = 1'b1;
          else begin
            iss   = 1'b1;
            iss_w = 1'b1;
            iss_a = addr_q;
          end
        end
        S_RBEGIN, S_RDATA: begin
          if (state == S_RBEGIN && rx_word != RD_GO_TOKEN) flag_set[FL_PRERR] = 1'b1;
          else if (consume) begin
            if (rbuf_v) tx_word = rbuf;
            else        flag_set[FL_RERR] = 1'b1;
          end
        end
        default: ;
      endcase
    end else if (fetch_ok) begin
      iss = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_CMD;
      addr_q     <= '0;
      fetch_addr <= '0;
      left_q     <= '0;
      fetch_left <= '0;
      rbuf       <= '0;
      rbuf_v     <= 1'b0;
      rd_out     <= 1'b0;
      drop_q     <= 1'b0;
      ctrl0_q    <= '0;
    end else begin
      if (req_valid && req_ready && !req_write) rd_out <= 1'b1;
      if (rsp_valid) begin
        rd_out <= 1'b0;
        if (drop_q) drop_q <= 1'b0;
        else begin
          rbuf   <= rsp_rdata;
          rbuf_v <= 1'b1;
        end
      end
      if (fetch_ok) begin
        fetch_left <= fetch_left - 1'b1;
        fetch_addr <= fetch_addr + 32'd4;
      end
      if (frame_end) begin
        state      <= S_CMD;
        rbuf_v     <= 1'b0;
        fetch_left <= '0;
        drop_q     <= (rd_out && !rsp_valid) || (req_valid && !req_write) ||
                      (drop_q && !rsp_valid);
      end else if (word_done) begin
        case (state)
          S_CMD: begin
            if (rx_word == CMD_BURST_WR) begin
              state  <= S_WADDR;
              left_q <= MAX_WORDS;
            end else if (rx_word == CMD_CTRL_WR) state <= S_CDATA;
            else if (rx_word == CMD_STATUS)      state <= S_QDATA;
            else if (is_read_cmd) begin
              state      <= S_RADDR;
              left_q     <= rd_count;
              fetch_left <= rd_count;
            end else state <= S_SKIP;
          end
          S_WADDR: begin
            addr_q <= rx_word;
            state  <= S_WDATA;
          end
          S_WDATA: begin
            if (left_q != '0) begin
              left_q <= left_q - 1'b1;
              addr_q <= addr_q + 32'd4;
            end
          end
          S_CDATA: begin
            ctrl0_q <= rx_word;
            state   <= S_SKIP;
          end
          S_RADDR: begin
            fetch_addr <= rx_word;
            state      <= S_RDUMMY;
          end
          S_RDUMMY: state <= S_RBEGIN;
          S_RBEGIN: state <= (rx_word == RD_GO_TOKEN) ? S_RDATA : S_SKIP;
          default:  state <= (state == S_RDATA) ? S_RDATA : S_SKIP;
        endcase
        if (consume) begin
          left_q <= left_q - 1'b1;
          if (rbuf_v) rbuf_v <= 1'b0;
        end
      end
    end
  end

  assign ctrl0 = ctrl0_q;
endmodule

// File: rtl/sb_checker.sv
`timescale 1ns/1ps
module sb_checker
  import spi_bridge_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [31:0]       req_addr,
  input logic [31:0]       req_wdata,
  input logic              word_done,
  input op_state_e         state,
  input logic [WORD_W-1:0] rx_word,
  input logic [15:0]       left_q,
  input logic [FLAG_W-1:0] flags_q,
  input logic [31:0]       ctrl0
);
  // R3: request held stable until accepted
  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) &&
    $stable(req_wdata) && $stable(req_write));

  // R5: a write word past the limit issues nothing and flags overflow
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    word_done && state == S_WDATA && left_q == '0 |=>
    flags_q[FL_WOVF] && !$rose(req_valid));

  // R6: control load touches ctrl0 only
  p_ctrl_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    word_done && state == S_CDATA |=> ctrl0 == $past(rx_word) && !$rose(req_valid));

  // R9: wrong read-begin token raises pre-read error
  p_pre_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    word_done && state == S_RBEGIN && rx_word != RD_GO_TOKEN |=> flags_q[FL_PRERR]);

  // R11: flags clear when a query returns them
  p_status_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    word_done && state == S_CMD && rx_word == CMD_STATUS |=> flags_q == '0);
endmodule

bind spi_reg_bridge sb_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
  .word_done(word_done), .state(state), .rx_word(rx_word), .left_q(left_q),
  .flags_q(flags_q), .ctrl0(ctrl0)
);

// File: tb/test_spi_reg_bridge.sv
`timescale 1ns/1ps
module test_spi_reg_bridge;
  localparam int MAXB = 16;   // four-word limit for the bench
  localparam int HALF = 100;  // SCLK half period, ns

  logic clk = 1'b0, rst_n = 1'b0;
  logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic spi_miso, req_valid, req_write, rsp_valid = 1'b0, req_ready = 1'b0;
  logic [31:0] req_addr, req_wdata, rsp_rdata = '0, ctrl0;

  int checks = 0, fails = 0;
  logic stall = 1'b0;
  logic [31:0] mem [16];
  logic [31:0] wlog_a [64];
  logic [31:0] wlog_d [64];
  int wcnt = 0;
  logic finished = 1'b0;

  spi_reg_bridge #(.MAX_OP_BYTES(MAXB)) i_spi_reg_bridge (
    .clk, .rst_n, .spi_sclk, .spi_cs_n, .spi_mosi, .spi_miso,
    .req_valid, .req_ready, .req_write, .req_addr, .req_wdata,
    .rsp_valid, .rsp_rdata, .ctrl0
  );

  initial forever #5 clk = ~clk;

  function automatic logic [31:0] init_val(input int i);
    return {16'hC0DE, 8'(i), 8'(i * 7 + 1)};
  endfunction

  // register-bus model, acts on falling clock edges
  initial begin
    logic sv = 0, sr = 0, sw = 0, rp = 0;
    logic [31:0] sa = 0, sd = 0, ra = 0;
    for (int i = 0; i < 16; i++) mem[i] = init_val(i);
    forever begin
      @(negedge clk);
      rsp_valid = 1'b0;
      if (rp) begin
        rsp_valid = 1'b1;
        rsp_rdata = mem[ra[5:2]];
        rp = 0;
      end
      if (sv && sr) begin
        if (sw) begin
          wlog_a[wcnt] = sa; wlog_d[wcnt] = sd; wcnt++;
          mem[sa[5:2]] = sd;
        end else begin
          rp = 1; ra = sa;
        end
      end
      req_ready = !stall;
      sv = req_valid; sr = req_ready; sw = req_write; sa = req_addr; sd = req_wdata;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic xfer_bits(input logic [31:0] tx, input int nbits, output logic [31:0] rx);
    rx = '0;
    for (int k = 0; k < nbits; k++) begin
      int b;
      b = (k / 8) * 8 + 7 - (k % 8);
      spi_mosi = tx[b];
      #HALF;
      rx[b] = spi_miso;
      spi_sclk = 1'b1;
      #HALF;
      spi_sclk = 1'b0;
    end
  endtask

  task automatic xfer(input logic [31:0] tx, output logic [31:0] rx);
    xfer_bits(tx, 32, rx);
  endtask

  task automatic cs_lo;
    @(negedge clk);
    spi_cs_n = 1'b0;
    #HALF;
  endtask

  task automatic cs_hi;
    #HALF;
    spi_cs_n = 1'b1;
    #400;
  endtask

  task automatic query(input logic [31:0] exp, input string tag);
    logic [31:0] r;
    cs_lo; xfer(32'h0000_00FF, r); xfer(32'h0, r); cs_hi;
    check(tag, r, exp);
  endtask

  task automatic t_reset;
    check("R1 reset miso", {31'd0, spi_miso}, 32'd0);
    check("R3 reset req_valid", {31'd0, req_valid}, 32'd0);
    check("R6 reset ctrl0", ctrl0, 32'd0);
    query(32'h1608_0000, "R11 status after reset");
  endtask

  task automatic t_burst_write;
    logic [31:0] r;
    int base;
    base = wcnt;
    cs_lo;
    xfer(32'h0000_0011, r);
    check("R1 miso idle during command", r, 32'd0);
    xfer(32'h0000_0010, r);
    xfer(32'h1122_3344, r);
    xfer(32'h8899_AABB, r);
    xfer(32'h0F1E_2D3C, r);
    cs_hi;
    check("R2 write count", 32'(wcnt - base), 32'd3);
    check("R1 first word byte order", wlog_d[base], 32'h1122_3344);
    check("R2 first addr", wlog_a[base], 32'h10);
    check("R2 third addr stride", wlog_a[base + 2], 32'h18);
    check("R2 third data", wlog_d[base + 2], 32'h0F1E_2D3C);
  endtask

  task automatic t_read_back;
    logic [31:0] r;
    cs_lo;
    xfer(32'h0003_0077, r); xfer(32'h10, r); xfer(32'h0, r); xfer(32'hAA, r);
    xfer(32'h0, r); check("R7 read word0", r, 32'h1122_3344);
    xfer(32'h0, r); check("R7 read word1", r, 32'h8899_AABB);
    xfer(32'h0, r); check("R7 read word2", r, 32'h0F1E_2D3C);
    xfer(32'h0, r); check("R7 word past count is zero", r, 32'h0);
    cs_hi;
    query(32'h1608_0000, "R7 clean read leaves no flag");
  endtask

  task automatic t_ctrl;
    logic [31:0] r;
    int base;
    base = wcnt;
    cs_lo; xfer(32'h0003_0011, r); xfer(32'h0000_0008, r); xfer(32'hDEAD_BEEF, r); cs_hi;
    check("R6 ctrl0 loaded", ctrl0, 32'h8);
    check("R6 no bus write", 32'(wcnt - base), 32'd0);
  endtask

  task automatic t_overflow;
    logic [31:0] r;
    int base;
    base = wcnt;
    cs_lo;
    xfer(32'h0000_0011, r); xfer(32'h20, r);
    for (int i = 0; i < 6; i++) xfer(32'h5000_0000 + 32'(i), r);
    cs_hi;
    check("R5 only limit words written", 32'(wcnt - base), 32'd4);
    check("R5 last written addr", wlog_a[wcnt - 1], 32'h2C);
    query(32'h1608_0002, "R5 overflow flag");
    query(32'h1608_0000, "R11 flag cleared after report");
  endtask

  task automatic t_underflow;
    logic [31:0] r;
    cs_lo;
    xfer(32'h0005_0077, r); xfer(32'h0, r); xfer(32'h0, r); xfer(32'hAA, r);
    for (int i = 0; i < 4; i++) begin
      xfer(32'h0, r);
      check("R8 clamped read data", r, init_val(i));
    end
    xfer(32'h0, r); check("R8 word past clamp is zero", r, 32'h0);
    cs_hi;
    query(32'h1608_0200, "R8 underflow flag");
  endtask

  task automatic t_prebad;
    logic [31:0] r;
    cs_lo;
    xfer(32'h0001_0077, r); xfer(32'h0, r); xfer(32'h0, r); xfer(32'hAB, r);
    xfer(32'h0, r); check("R9 no data after bad token", r, 32'h0);
    cs_hi;
    query(32'h1608_0400, "R9 pre-read flag");
  endtask

  task automatic t_abort;
    logic [31:0] r;
    int base;
    base = wcnt;
    cs_lo;
    xfer(32'h0000_0011, r); xfer(32'h34, r); xfer(32'h7777_0001, r);
    xfer_bits(32'h7777_0002, 13, r);
    cs_hi;
    check("R12 partial word not written", 32'(wcnt - base), 32'd1);
    query(32'h1608_0004, "R12 write unfinished flag");
  endtask

  task automatic t_write_err;
    logic [31:0] r;
    int base;
    base = wcnt;
    @(negedge clk); stall = 1'b1;
    cs_lo;
    xfer(32'h0000_0011, r); xfer(32'h30, r); xfer(32'hA1A1_0001, r); xfer(32'hB2B2_0002, r);
    cs_hi;
    check("R3 request held valid", {31'd0, req_valid}, 32'd1);
    check("R3 request addr held", req_addr, 32'h30);
    check("R3 request data held", req_wdata, 32'hA1A1_0001);
    @(negedge clk); stall = 1'b0;
    repeat (10) @(negedge clk);
    check("R4 only first word written", 32'(wcnt - base), 32'd1);
    check("R4 written data", wlog_d[wcnt - 1], 32'hA1A1_0001);
    query(32'h1608_0001, "R4 write error flag");
  endtask

  task automatic t_read_err;
    logic [31:0] r;
    @(negedge clk); stall = 1'b1;
    cs_lo;
    xfer(32'h0001_0077, r); xfer(32'h0, r); xfer(32'h0, r); xfer(32'hAA, r);
    xfer(32'h0, r); check("R10 late data sent as zero", r, 32'h0);
    cs_hi;
    @(negedge clk); stall = 1'b0;
    repeat (20) @(negedge clk);
    query(32'h1608_0100, "R10 read error flag");
  endtask

  task automatic t_unknown;
    logic [31:0] r;
    int base;
    base = wcnt;
    cs_lo; xfer(32'h1234_5678, r); xfer(32'h10, r); xfer(32'h9999_9999, r); cs_hi;
    check("R13 no request", 32'(wcnt - base), 32'd0);
    check("R13 ctrl0 unchanged", ctrl0, 32'h8);
    query(32'h1608_0000, "R13 no flag");
  endtask

  initial begin
    #1_800_000;
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset;
    t_burst_write;
    t_read_back;
    t_ctrl;
    t_overflow;
    t_underflow;
    t_prebad;
    t_abort;
    t_write_err;
    t_read_err;
    t_unknown;
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule